// File: doc/BRIEF.md
# Integer Add/Subtract/Shift Unit

This block is the integer arithmetic slice of a processor execution stage. It adds two register operands, subtracts one from the other, adds a sign-extended 16-bit immediate to the first operand, or shifts the first operand left, logically right or arithmetically right by a 5-bit amount. A signed/unsigned select controls whether arithmetic overflow raises a trap flag. The result bits are the same either way.

Subtraction does not use a separate subtractor. The subtrahend is bit-inverted and the adder's carry-in is set, which adds its two's complement. Overflow is taken from the sign bits of the two adder inputs and of the sum. The result and the trap flag are registered, so they appear one clock after the inputs are presented. When the trap is raised, the result still holds the wrapped sum, and the consumer decides whether to discard the write.

Top module: `intarith_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 and `ovf_trap` becomes 0 on that edge.
- R2: With `op_sel` = 0 (add), `result` equals `opnd_a + opnd_b` modulo 2^32 one clock after the inputs are sampled.
- R3: With `op_sel` = 1 (subtract), `result` equals `opnd_a - opnd_b` modulo 2^32, formed by adding the inverted `opnd_b` with a carry-in of one.
- R4: With `op_sel` = 2 (add immediate), `result` equals `opnd_a` plus `imm16` sign-extended from bit 15. The extension is applied whatever the value of `is_signed`.
- R5: When `is_signed` = 1 and `op_sel` is 0, 1 or 2, `ovf_trap` is 1 exactly when the true signed result lies outside [-2^31, 2^31-1]. An add of two operands with opposite signs never raises it.
- R6: When `is_signed` = 0, `ovf_trap` stays 0, and `result` carries the same bits the signed variant would produce.
- R7: When `ovf_trap` is 1, `result` still holds the wrapped 32-bit sum.
- R8: With `op_sel` = 3, `result` is `opnd_a` shifted left by `shamt`. The low bits fill with 0 and bits shifted past bit 31 are lost.
- R9: With `op_sel` = 4, `result` is `opnd_a` shifted right by `shamt` with zeros filling the upper bits.
- R10: With `op_sel` = 5, `result` is `opnd_a` shifted right by `shamt` with copies of bit 31 filling the upper bits.
- R11: A `shamt` of 0 passes `opnd_a` through a shift unchanged. Shift operations never raise `ovf_trap`, whatever the value of `is_signed`.
- R12: The unused `op_sel` codes 6 and 7 give `result` = 0 and `ovf_trap` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation: 0 add, 1 sub, 2 add-immediate, 3 shift left, 4 logical right, 5 arithmetic right |
| is_signed | input | 1 | 1 lets arithmetic overflow raise the trap |
| opnd_a | input | 32 | First operand; also the value that is shifted |
| opnd_b | input | 32 | Second operand (addend or subtrahend) |
| imm16 | input | 16 | Immediate for add-immediate, sign-extended |
| shamt | input | 5 | Shift distance 0 to 31 |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | Registered signed-overflow trap |

## Verification
The unit holds no state except the output register, so any internal fault shows at the ports on the clock after the offending inputs are applied. Every clock is compared against a reference computed at 64-bit width. A wrong carry-in or a wrong operand inversion corrupts the subtract result immediately. A wrong fill bit appears on the first negative operand shifted right. A faulty overflow term shows up as a missing or spurious trap at the sign boundaries: the most negative and most positive values, minus the most negative value, and sign-mixed adds.

// File: rtl/intarith_pkg.sv
package intarith_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_SLL  = 3'd3,
    OP_SRL  = 3'd4,
    OP_SRA  = 3'd5
  } arith_op_e;
endpackage

// File: rtl/intarith_addsub.sv
module intarith_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] rhs_eff;
  logic [W-1:0] cin_vec;

  // subtract = add inverted operand with carry-in of one
  assign rhs_eff = do_sub ? ~rhs : rhs;
  assign cin_vec = {{(W-1){1'b0}}, do_sub};
  assign sum     = lhs + rhs_eff + cin_vec;

  // overflow: adder inputs agree in sign, sum disagrees
  assign ovf = (lhs[W-1] == rhs_eff[W-1]) && (sum[W-1] != lhs[W-1]);
endmodule

// File: rtl/intarith_shift.sv
module intarith_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  logic           go_left,
  input  logic           sign_fill,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [SHW+1];
  logic         fill;

  assign fill     = sign_fill & din[W-1];
  assign stage[0] = din;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [W-1:0] moved;
    assign moved = go_left ? {stage[i][W-1-D:0], {D{1'b0}}}
                           : {{D{fill}}, stage[i][W-1:D]};
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/intarith_unit.sv
module intarith_unit
  import intarith_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_sel,
  input  logic             is_signed,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SHW-1:0]   shamt,
  output logic [W-1:0]     result,
  output logic             ovf_trap
);
  localparam int EXT_W = W - IMM_W;

  arith_op_e    op;
  logic [W-1:0] imm_ext;
  logic [W-1:0] add_rhs;
  logic [W-1:0] add_sum;
  logic         add_ovf;
  logic [W-1:0] sh_out;
  logic [W-1:0] nxt_result;
  logic         nxt_trap;

  assign op      = arith_op_e'(op_sel);
  assign imm_ext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
  assign add_rhs = (op == OP_ADDI) ? imm_ext : opnd_b;

  intarith_addsub #(.W(W)) u_addsub (
    .lhs    (opnd_a),
    .rhs    (add_rhs),
    .do_sub (op == OP_SUB),
    .sum    (add_sum),
    .ovf    (add_ovf)
  );

  intarith_shift #(.W(W), .SHW(SHW)) u_shift (
    .din       (opnd_a),
    .amt       (shamt),
    .go_left   (op == OP_SLL),
    .sign_fill (op == OP_SRA),
    .dout      (sh_out)
  );

  always_comb begin
    nxt_result = '0;
    nxt_trap   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDI: begin
        nxt_result = add_sum;
        nxt_trap   = is_signed & add_ovf;
      end
      OP_SLL, OP_SRL, OP_SRA: nxt_result = sh_out;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      ovf_trap <= 1'b0;
    end else begin
      result   <= nxt_result;
      ovf_trap <= nxt_trap;
    end
  end
endmodule

// File: rtl/intarith_unit_chk.sv
module intarith_unit_chk #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     op_sel,
  input logic           is_signed,
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic [SHW-1:0] shamt,
  input logic [W-1:0]   result,
  input logic           ovf_trap
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0) && !ovf_trap);

  a_r6_unsigned_no_trap: assert property (@(posedge clk) disable iff (rst)
    !is_signed |=> !ovf_trap);

  a_r5_mixed_sign_add: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd0 && opnd_a[W-1] != opnd_b[W-1]) |=> !ovf_trap);

  a_r11_shift_no_trap: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 3'd3) |=> !ovf_trap);

  a_r11_zero_shift: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 3'd3 && op_sel <= 3'd5 && shamt == '0) |=> (result == $past(opnd_a)));

  a_r7_wrapped_sign: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> (result[W-1] != $past(opnd_a[W-1])));

  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 3'd6) |=> (result == '0));
endmodule

bind intarith_unit intarith_unit_chk #(.W(W), .SHW(SHW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_sel    (op_sel),
  .is_signed (is_signed),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .shamt     (shamt),
  .result    (result),
  .ovf_trap  (ovf_trap)
);

// File: tb/intarith_unit_tb_top.sv
module intarith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic        is_signed = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_trap;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  intarith_unit dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .is_signed(is_signed),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .shamt(shamt),
    .result(result), .ovf_trap(ovf_trap)
  );

  function automatic string req_tag(input logic [2:0] op, input logic sg);
    case (op)
      3'd0: return sg ? "R2/R5" : "R2/R6";
      3'd1: return sg ? "R3/R5" : "R3/R6";
      3'd2: return sg ? "R4/R5" : "R4/R6";
      3'd3: return "R8/R11";
      3'd4: return "R9/R11";
      3'd5: return "R10/R11";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic sg, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    longint x, y, t;
    logic [31:0] exp_r;
    logic        exp_t;
    x = longint'($signed(a));
    y = longint'($signed(b));
    exp_t = 1'b0;
    case (op)
      3'd0: t = x + y;
      3'd1: t = x - y;
      3'd2: t = x + longint'($signed(im));
      default: t = 0;
    endcase
    case (op)
      3'd0, 3'd1, 3'd2: begin
        exp_r = t[31:0];
        exp_t = sg && (t > 64'sd2147483647 || t < -64'sd2147483648);
      end
      3'd3: exp_r = a << sh;
      3'd4: exp_r = a >> sh;
      3'd5: exp_r = 32'($signed(a) >>> sh);
      default: exp_r = '0;
    endcase
    op_sel = op; is_signed = sg; opnd_a = a; opnd_b = b; imm16 = im; shamt = sh;
    @(negedge clk);
    checks++;
    if (result !== exp_r || ovf_trap !== exp_t) begin
      failures++;
      $display("FAIL %s%s op=%0d a=%h b=%h imm=%h sh=%0d: result=%h trap=%b expected result=%h trap=%b",
               req_tag(op, sg), exp_t ? "/R7" : "", op, a, b, im, sh,
               result, ovf_trap, exp_r, exp_t);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: drive a nonzero op first, then reset
    @(negedge clk);
    rst = 1'b1; op_sel = 3'd0; is_signed = 1'b1;
    opnd_a = 32'h7fff_ffff; opnd_b = 32'h1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || ovf_trap !== 1'b0) begin
      failures++;
      $display("FAIL R1: result=%h trap=%b expected result=0 trap=0", result, ovf_trap);
    end
    rst = 1'b0;

    // R2 add, R5 overflow at both edges
    apply(3'd0, 1, 32'd5, 32'd7, 16'h0, 5'd0);
    apply(3'd0, 1, 32'h7fff_ffff, 32'h1, 16'h0, 5'd0);   // R5/R7 positive flip
    apply(3'd0, 1, 32'h8000_0000, 32'hffff_ffff, 16'h0, 5'd0); // R5 negative flip
    apply(3'd0, 1, 32'h8000_0000, 32'h7fff_ffff, 16'h0, 5'd0); // R5 mixed sign
    apply(3'd0, 0, 32'h7fff_ffff, 32'h1, 16'h0, 5'd0);   // R6 same bits, no trap
    // R3 subtract
    apply(3'd1, 1, 32'd6, 32'd21, 16'h0, 5'd0);
    apply(3'd1, 1, 32'h0, 32'h8000_0000, 16'h0, 5'd0);   // R5 minus most negative
    apply(3'd1, 1, 32'hffff_ffff, 32'h8000_0000, 16'h0, 5'd0);
    apply(3'd1, 1, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
    apply(3'd1, 0, 32'h8000_0000, 32'h1, 16'h0, 5'd0);   // R6
    // R4 immediate sign extension in both modes
    apply(3'd2, 0, 32'd10, 32'h0, 16'hfffd, 5'd0);
    apply(3'd2, 1, 32'h7fff_fff0, 32'h0, 16'h7fff, 5'd0);
    apply(3'd2, 1, 32'h8000_0000, 32'h0, 16'h8000, 5'd0);
    // R8..R11 shifts
    apply(3'd3, 1, 32'h0000_0036, 32'h0, 16'h0, 5'd3);
    apply(3'd3, 0, 32'hffff_ffff, 32'h0, 16'h0, 5'd31);
    apply(3'd4, 1, 32'h8000_0036, 32'h0, 16'h0, 5'd3);
    apply(3'd5, 1, 32'h8000_0036, 32'h0, 16'h0, 5'd3);
    apply(3'd5, 0, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
    apply(3'd5, 1, 32'h4000_0000, 32'h0, 16'h0, 5'd30);
    apply(3'd3, 1, 32'hdead_beef, 32'h0, 16'h0, 5'd0);
    apply(3'd4, 1, 32'hdead_beef, 32'h0, 16'h0, 5'd0);
    apply(3'd5, 1, 32'hdead_beef, 32'h0, 16'h0, 5'd0);
    // R12 unused codes
    apply(3'd6, 1, 32'h7fff_ffff, 32'h1, 16'h1, 5'd1);
    apply(3'd7, 0, 32'h1234_5678, 32'h1, 16'h1, 5'd1);

    // mixed patterns, biased toward sign boundaries
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (n % 5 == 0) a = {a[31], {31{~a[31]}}};
      if (n % 7 == 0) b = {b[31], {31{~b[31]}}};
      apply(3'($urandom_range(0, 7)), 1'($urandom()), a, b, 16'($urandom()), 5'($urandom()));
    end

    // R1 again mid-run
    op_sel = 3'd0; is_signed = 1'b1; opnd_a = 32'h7fff_ffff; opnd_b = 32'h7fff_ffff;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || ovf_trap !== 1'b0) begin
      failures++;
      $display("FAIL R1: result=%h trap=%b expected result=0 trap=0", result, ovf_trap);
    end
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule